// File: doc/BRIEF.md
# Configuration Bitstream Loader

This block loads configuration data into an attached programmable-logic device. It draws the data from a byte stream and drives the target's control lines through a timed sequence. When started, it first confirms from a control/status word that a configuration memory is fitted. It then pulses a local-bus reset, a reload and a program line, each step held for a fixed number of clocks. Next it polls the target's INIT flag at a slower interval until the flag rises. It discards input bytes up to a two-byte header marker. From the marker onward it packs byte pairs into 16-bit words and writes them to the target, checking INIT after every write.

If INIT never rises, or falls after a word, the attempt is abandoned and the whole sequence starts again. Before each attempt the block asks the byte source to rewind. At most three attempts are made. A successful load ends with one more local-bus reset and reload, and then a one-cycle done pulse. A final failure, or a missing configuration memory, produces a one-cycle error pulse instead. All wait intervals are parameters counted in clock cycles, so the same logic serves any clock rate.

Top module: `bitstream_loader`

## Requirements
- R1: A start seen while idle, with bit 28 of `ctlStatus` clear, produces `errPulse` on the next cycle. In that case no rewind is issued, no control pulse is driven and `busy` stays low.
- R2: Each local-bus reset drives `ctlWord` to 0xC000767E for PULSE_WAIT cycles and then to 0x8000767E for PULSE_WAIT cycles. It happens once per attempt plus once at the end of a successful load.
- R3: Each reload drives 0x8000767E, then 0xA000767E, then 0x8000767E, each for PULSE_WAIT cycles. It happens as often as the bus reset.
- R4: Each attempt pulses the program line by driving 0x8001767E for PULSE_WAIT cycles, followed by 0x8000767E for PULSE_WAIT cycles. The idle value of `ctlWord` is 0x8000767E.
- R5: After the program pulse, INIT (bit 1 of `tgtStatus`) is sampled up to POLL_MAX times, POLL_GAP+1 cycles apart. If INIT is never high at a sample, the attempt fails.
- R6: Bytes are dropped until a 0xFF byte is directly followed by 0x20. From that 0xFF onward, byte pairs form words with the first byte in bits 15:8, and each word is written on `tgtWrData` with a one-cycle `tgtWrEn`.
- R7: Every word write is preceded by WORD_GAP cycles in which no byte is accepted and no write occurs. With bytes always available, consecutive writes are WORD_GAP+4 cycles apart.
- R8: If INIT is low in the cycle after a word write, the attempt is aborted. The next attempt restarts from the bus reset with a new `rewind` pulse.
- R9: At most RETRY_MAX attempts are made, each announced by one `rewind` pulse. Success ends with the final reset and reload and a one-cycle `donePulse` as `busy` falls. Exhausting the attempts gives a one-cycle `errPulse`.
- R10: When the stream holds an odd number of bytes from the marker on, the last word carries that byte in bits 15:8 and 0x00 in bits 7:0.
- R11: A start received while `busy` is high has no effect: it causes no extra rewind, and no second done or error pulse.
- R12: A stream that ends without a marker writes no words, and the attempt completes successfully.
- R13: Out of reset, `busy`, `byteReady`, `tgtWrEn`, `rewind`, `donePulse` and `errPulse` are low, and `ctlWord` holds 0x8000767E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| streamLen | input | LEN_W | Number of bytes in the stream, taken at each attempt |
| ctlWord | output | 32 | Control word driving reset, reload and program lines |
| ctlStatus | input | 32 | Control/status readback; bit 28 flags a configuration memory |
| byteValid | input | 1 | Stream byte available |
| byteData | input | 8 | Stream byte |
| byteReady | output | 1 | Loader accepts the byte this cycle |
| rewind | output | 1 | One-cycle request to restart the stream from its first byte |
| tgtWrEn | output | 1 | Word write strobe to the target |
| tgtWrData | output | 16 | Word written to the target |
| tgtStatus | input | 16 | Target status; bit 1 is INIT |
| busy | output | 1 | A load is in progress |
| donePulse | output | 1 | One cycle on successful completion |
| errPulse | output | 1 | One cycle on refusal or final failure |

## Verification
The bound checker watches several properties on every cycle:
- the refusal when the memory bit is clear;
- the enforced quiet gap before each word write;
- the cap on rewinds within one run;
- the legal set of control words;
- the pairing of done and error pulses with `busy` falling.

Other behaviour can only be shown by the bench's scenarios, because it depends on the contents and timing of the stream and the target:
- the exact words produced from a given stream, including marker hunting over repeated 0xFF bytes and padding of an odd tail;
- the duration of each pulse phase;
- the INIT poll boundary;
- recovery after INIT drops mid-stream.

// File: rtl/bitstream_loader_pkg.sv
package bitstream_loader_pkg;

  localparam logic [31:0] CW_IDLE   = 32'h8000_767E;
  localparam logic [31:0] CW_BUSRST = 32'hC000_767E;
  localparam logic [31:0] CW_RELOAD = 32'hA000_767E;
  localparam logic [31:0] CW_PROG   = 32'h8001_767E;

  localparam int MEM_PRESENT_BIT = 28;
  localparam int INIT_BIT        = 1;

  localparam logic [7:0] MARK_FIRST  = 8'hFF;
  localparam logic [7:0] MARK_SECOND = 8'h20;

  typedef enum logic [4:0] {
    S_IDLE, S_RST_HI, S_RST_LO, S_RLD_LO1, S_RLD_HI, S_RLD_LO2,
    S_PRG_HI, S_PRG_LO, S_POLL, S_POLL_WAIT, S_HUNT, S_GET_HI,
    S_GET_LO, S_GAP, S_WRITE, S_CHECK, S_FAIL
  } ldState_t;

  typedef enum logic [1:0] { T_PULSE, T_POLL, T_GAP } tmrSel_t;

  typedef struct packed {
    logic    tmrLoad;
    tmrSel_t tmrSel;
    logic    attemptInit;
    logic    takeByte;
    logic    markWord;
    logic    latchHi;
    logic    latchLo;
    logic    padLo;
    logic    pollClr;
    logic    pollInc;
    logic    retryClr;
    logic    retryInc;
  } dpCtl_t;

endpackage

// File: rtl/bitstream_loader_dp.sv
module bitstream_loader_dp
  import bitstream_loader_pkg::*;
#(
  parameter int PULSE_WAIT = 1000000,
  parameter int POLL_GAP   = 10000,
  parameter int WORD_GAP   = 1000,
  parameter int POLL_MAX   = 50,
  parameter int RETRY_MAX  = 3,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [LEN_W-1:0] streamLen,
  input  logic [7:0]       byteData,
  output logic             timerDone,
  output logic             streamEmpty,
  output logic             lastPoll,
  output logic             lastRetry,
  output logic             markerSeen,
  output logic [15:0]      wordOut
);

  localparam int MAX_A   = (PULSE_WAIT > POLL_GAP) ? PULSE_WAIT : POLL_GAP;
  localparam int TMR_MAX = (MAX_A > WORD_GAP) ? MAX_A : WORD_GAP;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PCW     = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int RCW     = (RETRY_MAX > 1) ? $clog2(RETRY_MAX) : 1;

  logic [TMR_W-1:0] tmr, ldVal;
  logic [LEN_W-1:0] left;
  logic [PCW-1:0]   pollCnt;
  logic [RCW-1:0]   retryCnt;
  logic             prevFF;

  always_comb begin
    unique case (ctl.tmrSel)
      T_PULSE: ldVal = TMR_W'(PULSE_WAIT - 1);
      T_POLL:  ldVal = TMR_W'(POLL_GAP - 1);
      default: ldVal = TMR_W'(WORD_GAP - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (ctl.tmrLoad)   tmr <= ldVal;
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      left   <= '0;
      prevFF <= 1'b0;
    end else if (ctl.attemptInit) begin
      left   <= streamLen;
      prevFF <= 1'b0;
    end else if (ctl.takeByte) begin
      left   <= left - 1'b1;
      prevFF <= (byteData == MARK_FIRST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordOut <= '0;
    else if (ctl.markWord) wordOut <= {MARK_FIRST, MARK_SECOND};
    else if (ctl.latchHi)  wordOut[15:8] <= byteData;
    else if (ctl.latchLo)  wordOut[7:0]  <= byteData;
    else if (ctl.padLo)    wordOut[7:0]  <= 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pollCnt <= '0;
    else if (ctl.pollClr)  pollCnt <= '0;
    else if (ctl.pollInc)  pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              retryCnt <= '0;
    else if (ctl.retryClr)  retryCnt <= '0;
    else if (ctl.retryInc)  retryCnt <= retryCnt + 1'b1;
  end

  assign timerDone   = (tmr == '0);
  assign streamEmpty = (left == '0);
  assign lastPoll    = (pollCnt == PCW'(POLL_MAX - 1));
  assign lastRetry   = (retryCnt == RCW'(RETRY_MAX - 1));
  assign markerSeen  = prevFF && (byteData == MARK_SECOND);

endmodule

// File: rtl/bitstream_loader_ctrl.sv
module bitstream_loader_ctrl
  import bitstream_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memPresent,
  input  logic        initLvl,
  input  logic        byteValid,
  input  logic        timerDone,
  input  logic        streamEmpty,
  input  logic        lastPoll,
  input  logic        lastRetry,
  input  logic        markerSeen,
  output dpCtl_t      ctl,
  output logic [31:0] ctlWord,
  output logic        byteReady,
  output logic        tgtWrEn,
  output logic        busy,
  output logic        donePulse,
  output logic        errPulse
);

  ldState_t state, nxt;
  logic     finalPh, finalN, doneN, errN;

  always_comb begin
    nxt    = state;
    ctl    = '0;
    finalN = finalPh;
    doneN  = 1'b0;
    errN   = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        if (memPresent) begin
          nxt = S_RST_HI; finalN = 1'b0;
          ctl.attemptInit = 1'b1; ctl.retryClr = 1'b1;
          ctl.tmrLoad = 1'b1; ctl.tmrSel = T_PULSE;
        end else errN = 1'b1;
      end
      S_RST_HI:  if (timerDone) begin nxt = S_RST_LO;  ctl.tmrLoad = 1'b1; end
      S_RST_LO:  if (timerDone) begin nxt = S_RLD_LO1; ctl.tmrLoad = 1'b1; end
      S_RLD_LO1: if (timerDone) begin nxt = S_RLD_HI;  ctl.tmrLoad = 1'b1; end
      S_RLD_HI:  if (timerDone) begin nxt = S_RLD_LO2; ctl.tmrLoad = 1'b1; end
      S_RLD_LO2: if (timerDone) begin
        if (finalPh) begin nxt = S_IDLE; doneN = 1'b1; end
        else begin nxt = S_PRG_HI; ctl.tmrLoad = 1'b1; end
      end
      S_PRG_HI:  if (timerDone) begin nxt = S_PRG_LO; ctl.tmrLoad = 1'b1; end
      S_PRG_LO:  if (timerDone) begin nxt = S_POLL; ctl.pollClr = 1'b1; end
      S_POLL: begin
        if (initLvl)       nxt = S_HUNT;
        else if (lastPoll) nxt = S_FAIL;
        else begin
          nxt = S_POLL_WAIT; ctl.pollInc = 1'b1;
          ctl.tmrLoad = 1'b1; ctl.tmrSel = T_POLL;
        end
      end
      S_POLL_WAIT: if (timerDone) nxt = S_POLL;
      S_HUNT: begin
        if (streamEmpty) begin
          nxt = S_RST_HI; finalN = 1'b1; ctl.tmrLoad = 1'b1;
        end else if (byteValid) begin
          ctl.takeByte = 1'b1;
          if (markerSeen) begin
            ctl.markWord = 1'b1; nxt = S_GAP;
            ctl.tmrLoad = 1'b1; ctl.tmrSel = T_GAP;
          end
        end
      end
      S_GET_HI: begin
        if (streamEmpty) begin
          nxt = S_RST_HI; finalN = 1'b1; ctl.tmrLoad = 1'b1;
        end else if (byteValid) begin
          ctl.takeByte = 1'b1; ctl.latchHi = 1'b1; nxt = S_GET_LO;
        end
      end
      S_GET_LO: begin
        if (streamEmpty) begin
          ctl.padLo = 1'b1; nxt = S_GAP;
          ctl.tmrLoad = 1'b1; ctl.tmrSel = T_GAP;
        end else if (byteValid) begin
          ctl.takeByte = 1'b1; ctl.latchLo = 1'b1; nxt = S_GAP;
          ctl.tmrLoad = 1'b1; ctl.tmrSel = T_GAP;
        end
      end
      S_GAP:   if (timerDone) nxt = S_WRITE;
      S_WRITE: nxt = S_CHECK;
      S_CHECK: nxt = initLvl ? S_GET_HI : S_FAIL;
      S_FAIL: begin
        if (lastRetry) begin nxt = S_IDLE; errN = 1'b1; end
        else begin
          nxt = S_RST_HI; ctl.retryInc = 1'b1; ctl.attemptInit = 1'b1;
          ctl.tmrLoad = 1'b1; ctl.tmrSel = T_PULSE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      finalPh   <= 1'b0;
      donePulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= nxt;
      finalPh   <= finalN;
      donePulse <= doneN;
      errPulse  <= errN;
    end
  end

  always_comb begin
    unique case (state)
      S_RST_HI: ctlWord = CW_BUSRST;
      S_RLD_HI: ctlWord = CW_RELOAD;
      S_PRG_HI: ctlWord = CW_PROG;
      default:  ctlWord = CW_IDLE;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign tgtWrEn   = (state == S_WRITE);
  assign byteReady = ((state == S_HUNT) || (state == S_GET_HI) ||
                      (state == S_GET_LO)) && !streamEmpty;

endmodule

// File: rtl/bitstream_loader.sv
module bitstream_loader
  import bitstream_loader_pkg::*;
#(
  parameter int PULSE_WAIT = 1000000,
  parameter int POLL_GAP   = 10000,
  parameter int WORD_GAP   = 1000,
  parameter int POLL_MAX   = 50,
  parameter int RETRY_MAX  = 3,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] streamLen,
  output logic [31:0]      ctlWord,
  input  logic [31:0]      ctlStatus,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             byteReady,
  output logic             rewind,
  output logic             tgtWrEn,
  output logic [15:0]      tgtWrData,
  input  logic [15:0]      tgtStatus,
  output logic             busy,
  output logic             donePulse,
  output logic             errPulse
);

  dpCtl_t ctl;
  logic   timerDone, streamEmpty, lastPoll, lastRetry, markerSeen;
  logic   unusedStatusBits;

  assign unusedStatusBits = ^{ctlStatus[31:29], ctlStatus[27:0],
                              tgtStatus[15:2], tgtStatus[0]};

  bitstream_loader_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memPresent (ctlStatus[MEM_PRESENT_BIT]),
    .initLvl    (tgtStatus[INIT_BIT]),
    .byteValid  (byteValid),
    .timerDone  (timerDone),
    .streamEmpty(streamEmpty),
    .lastPoll   (lastPoll),
    .lastRetry  (lastRetry),
    .markerSeen (markerSeen),
    .ctl        (ctl),
    .ctlWord    (ctlWord),
    .byteReady  (byteReady),
    .tgtWrEn    (tgtWrEn),
    .busy       (busy),
    .donePulse  (donePulse),
    .errPulse   (errPulse)
  );

  bitstream_loader_dp #(
    .PULSE_WAIT(PULSE_WAIT), .POLL_GAP(POLL_GAP), .WORD_GAP(WORD_GAP),
    .POLL_MAX(POLL_MAX), .RETRY_MAX(RETRY_MAX), .LEN_W(LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .streamLen  (streamLen),
    .byteData   (byteData),
    .timerDone  (timerDone),
    .streamEmpty(streamEmpty),
    .lastPoll   (lastPoll),
    .lastRetry  (lastRetry),
    .markerSeen (markerSeen),
    .wordOut    (tgtWrData)
  );

  assign rewind = ctl.attemptInit;

endmodule

// File: rtl/bitstream_loader_chk.sv
module bitstream_loader_chk
  import bitstream_loader_pkg::*;
#(
  parameter int WORD_GAP  = 1000,
  parameter int RETRY_MAX = 3
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        memPresent,
  input logic [31:0] ctlWord,
  input logic        byteValid,
  input logic        byteReady,
  input logic        rewind,
  input logic        tgtWrEn,
  input logic        busy,
  input logic        donePulse,
  input logic        errPulse
);

  localparam int QW = $clog2(WORD_GAP + 1);
  localparam int RW = $clog2(RETRY_MAX + 2);

  logic [QW-1:0] quiet;
  logic [RW-1:0] rewinds;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              quiet <= '0;
    else if (rewind || (byteValid && byteReady)) quiet <= '0;
    else if (tgtWrEn)                       quiet <= '0;
    else if (quiet < QW'(WORD_GAP))         quiet <= quiet + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rewinds <= '0;
    else if (rewind && !busy)  rewinds <= RW'(1);
    else if (rewind)           rewinds <= rewinds + 1'b1;
  end

  // R1
  refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !memPresent) |=> (errPulse && !busy));

  // R7
  word_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtWrEn |-> (quiet >= QW'(WORD_GAP)));

  // R9
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rewinds <= RW'(RETRY_MAX));

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || errPulse) |-> (!busy && !(donePulse && errPulse)));

  // R6
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtWrEn |-> (busy && !byteReady));

  // R4
  ctl_word_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWord != CW_IDLE) |-> (busy && ((ctlWord == CW_BUSRST) ||
      (ctlWord == CW_RELOAD) || (ctlWord == CW_PROG))));

endmodule

bind bitstream_loader bitstream_loader_chk #(
  .WORD_GAP(WORD_GAP), .RETRY_MAX(RETRY_MAX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .memPresent(ctlStatus[28]),
  .ctlWord   (ctlWord),
  .byteValid (byteValid),
  .byteReady (byteReady),
  .rewind    (rewind),
  .tgtWrEn   (tgtWrEn),
  .busy      (busy),
  .donePulse (donePulse),
  .errPulse  (errPulse)
);

// File: tb/bitstream_loader_test.sv
module bitstream_loader_test;

  localparam int PW = 4, PG = 3, WG = 2, PM = 5, RM = 3, LW = 8;
  localparam logic [31:0] W_IDLE = 32'h8000_767E, W_BUS = 32'hC000_767E;
  localparam logic [31:0] W_RLD = 32'hA000_767E, W_PRG = 32'h8001_767E;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [LW-1:0] streamLen = '0;
  logic [31:0] ctlWord, ctlStatus;
  logic byteValid, byteReady, rewind, tgtWrEn, busy, donePulse, errPulse;
  logic [7:0] byteData;
  logic [15:0] tgtWrData, tgtStatus;

  always #2 clk = ~clk;

  bitstream_loader #(.PULSE_WAIT(PW), .POLL_GAP(PG), .WORD_GAP(WG),
    .POLL_MAX(PM), .RETRY_MAX(RM), .LEN_W(LW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .streamLen(streamLen),
    .ctlWord(ctlWord), .ctlStatus(ctlStatus), .byteValid(byteValid),
    .byteData(byteData), .byteReady(byteReady), .rewind(rewind),
    .tgtWrEn(tgtWrEn), .tgtWrData(tgtWrData), .tgtStatus(tgtStatus),
    .busy(busy), .donePulse(donePulse), .errPulse(errPulse));

  // stream source and target model
  logic [7:0] mem [0:31];
  int cfgD [0:3];
  int cfgFail [0:3];
  logic memBit = 1'b1, clrStats = 1'b0;
  int ptr, nRew, nBus, nRld, nPrg, wrCnt, k, cyc, lastWr;
  logic armed, dropped, gapBad, initLvl;
  logic [15:0] cap [0:15];
  int idx;

  assign idx       = (nRew < 1) ? 0 : ((nRew > 3) ? 3 : nRew - 1);
  assign byteValid = (ptr < int'(streamLen)) && (ptr < 32);
  assign byteData  = (ptr < 32) ? mem[ptr] : 8'h00;
  assign initLvl   = armed && (k >= cfgD[idx]) && !dropped;
  assign tgtStatus = {8'hA5, 6'b0, initLvl, 1'b1};
  assign ctlStatus = {3'b010, memBit, 28'h0ABCDEF};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clrStats) begin
      ptr <= 0; nRew <= 0; nBus <= 0; nRld <= 0; nPrg <= 0; wrCnt <= 0;
      k <= 0; armed <= 1'b0; dropped <= 1'b0; gapBad <= 1'b0; lastWr <= 0;
    end else begin
      if (rewind) begin
        nRew <= nRew + 1; ptr <= 0; wrCnt <= 0; armed <= 1'b0;
        dropped <= 1'b0; lastWr <= 0;
      end else begin
        if (byteValid && byteReady) ptr <= ptr + 1;
        if (tgtWrEn) begin
          cap[wrCnt[3:0]] <= tgtWrData;
          wrCnt <= wrCnt + 1;
          if (wrCnt + 1 == cfgFail[idx]) dropped <= 1'b1;
          if (lastWr != 0 && cyc - lastWr != WG + 4) gapBad <= 1'b1;
          lastWr <= cyc;
        end
      end
      if (ctlWord == W_BUS) nBus <= nBus + 1;
      if (ctlWord == W_RLD) nRld <= nRld + 1;
      if (ctlWord == W_PRG) begin nPrg <= nPrg + 1; armed <= 1'b1; k <= 0; end
      else k <= k + 1;
    end
  end

  int checks = 0, errors = 0;
  logic [15:0] expW [0:15];
  int expN;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic calcExpected(input int n);
    int m = -1;
    expN = 0;
    for (int i = 0; i + 1 < n; i++)
      if (m < 0 && mem[i] == 8'hFF && mem[i+1] == 8'h20) m = i;
    if (m >= 0)
      for (int j = m; j < n; j += 2) begin
        expW[expN] = {mem[j], (j + 1 < n) ? mem[j+1] : 8'h00};
        expN++;
      end
  endtask

  task automatic runLoad(input int n, input int d0, input int d1, input int d2,
                         input int f0, input int f1, input bit midStart,
                         output bit gotDone, output bit gotErr);
    cfgD[0] = d0; cfgD[1] = d1; cfgD[2] = d2; cfgD[3] = 1000;
    cfgFail[0] = f0; cfgFail[1] = f1; cfgFail[2] = 0; cfgFail[3] = 0;
    @(negedge clk); streamLen = LW'(n); clrStats = 1'b1;
    @(negedge clk); clrStats = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    gotDone = 1'b0; gotErr = 1'b0;
    for (int t = 0; t < 5000 && !gotDone && !gotErr; t++) begin
      if (midStart && t == 30) start = 1'b1;
      if (midStart && t == 31) start = 1'b0;
      gotDone = donePulse; gotErr = errPulse;
      if (!gotDone && !gotErr) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    bit d, e;
    for (int i = 0; i < 4; i++) begin cfgD[i] = 0; cfgFail[i] = 0; end
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    clrStats = 1'b1;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !byteReady && !tgtWrEn && !rewind && !donePulse && !errPulse,
        "R13 outputs idle", {busy, byteReady, tgtWrEn, rewind}, 0);
    chk(ctlWord == W_IDLE, "R13 ctlWord", ctlWord, W_IDLE);
    rstN = 1'b1; clrStats = 1'b0;
    @(negedge clk);
    chk(!busy && ctlWord == W_IDLE, "R13 after release", ctlWord, W_IDLE);

    // R1 memory missing
    memBit = 1'b0;
    runLoad(4, 0, 0, 0, 0, 0, 1'b0, d, e);
    chk(e && !d, "R1 refused", e, 1);
    chk(nRew == 0 && nBus == 0, "R1 no sequence", nRew, 0);
    memBit = 1'b1;

    // R6 R10 R2 R3 R4 R7 sweep over prefix and payload lengths
    for (int pre = 0; pre < 4; pre++)
      for (int pay = 0; pay < 6; pay++) begin
        int n = pre + 2 + pay;
        for (int i = 0; i < pre; i++) mem[i] = (i == 1 || i == 2) ? 8'hFF : 8'h30 + 8'(i);
        mem[pre] = 8'hFF; mem[pre+1] = 8'h20;
        for (int j = 0; j < pay; j++) mem[pre+2+j] = 8'h41 + 8'(7 * j + pre);
        calcExpected(n);
        runLoad(n, 0, 0, 0, 0, 0, 1'b0, d, e);
        chk(d && !e, "R9 sweep done", d, 1);
        chk(nRew == 1, "R9 one attempt", nRew, 1);
        chk(wrCnt == expN, "R6 word count", wrCnt, expN);
        for (int w = 0; w < expN; w++)
          chk(cap[w] == expW[w], (pay % 2 == 1 && w == expN - 1) ? "R10 padded word" : "R6 word",
              cap[w], expW[w]);
        chk(!gapBad, "R7 write spacing", gapBad, 0);
        chk(nBus == 2 * PW, "R2 bus reset cycles", nBus, 2 * PW);
        chk(nRld == 2 * PW, "R3 reload cycles", nRld, 2 * PW);
        chk(nPrg == PW, "R4 program cycles", nPrg, PW);
      end

    // R12 no marker present
    mem[0] = 8'hFF; mem[1] = 8'h21; mem[2] = 8'h20; mem[3] = 8'hFF;
    runLoad(4, 0, 0, 0, 0, 0, 1'b0, d, e);
    chk(d && !e, "R12 done without marker", d, 1);
    chk(wrCnt == 0, "R12 no writes", wrCnt, 0);

    // R8 INIT drops after word 2 in first attempt
    mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'hFF; mem[3] = 8'h20;
    mem[4] = 8'hDE; mem[5] = 8'hAD; mem[6] = 8'hBE; mem[7] = 8'hEF;
    calcExpected(8);
    runLoad(8, 0, 0, 0, 2, 0, 1'b0, d, e);
    chk(d && !e, "R8 recovered", d, 1);
    chk(nRew == 2, "R8 second attempt", nRew, 2);
    chk(wrCnt == 3 && cap[2] == 16'hBEEF, "R8 words of retry", cap[2], 16'hBEEF);
    chk(nBus == 3 * PW && nPrg == 2 * PW, "R2 R4 per attempt", nBus, 3 * PW);

    // R5 INIT at the last poll sample is accepted
    runLoad(8, PW + (PM - 1) * (PG + 1) - 1, 0, 0, 0, 0, 1'b0, d, e);
    chk(d && nRew == 1, "R5 late INIT accepted", nRew, 1);

    // R5 R9 INIT too late on every attempt
    runLoad(8, 30, 30, 30, 0, 0, 1'b0, d, e);
    chk(e && !d, "R5 poll exhausted", e, 1);
    chk(nRew == RM, "R9 attempt cap", nRew, RM);
    chk(wrCnt == 0, "R5 no writes", wrCnt, 0);
    chk(nBus == RM * PW, "R9 no final reset", nBus, RM * PW);

    // R9 fail twice then succeed on last attempt
    runLoad(8, 1000, 1000, 0, 0, 0, 1'b0, d, e);
    chk(d && nRew == 3, "R9 third attempt done", nRew, 3);

    // R11 start while busy
    runLoad(8, 0, 0, 0, 0, 0, 1'b1, d, e);
    chk(d && nRew == 1, "R11 single attempt", nRew, 1);
    repeat (20) @(negedge clk);
    chk(!busy && nRew == 1, "R11 no restart", nRew, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule